// File: doc/BRIEF.md
# SPI Target Hold Gate

This block sits between the pins of an SPI target and its internal shift logic, and it pauses a transfer when the bus controller pulls the active-low hold pin. The pins are sampled by the chip's own clock through a short synchronizer. Edges of the serial clock are turned into single-cycle strobes: a capture strobe on each rising edge, which moves the data-in bit into an assembled word, and a drive strobe on each falling edge, which the output shifter uses to present its next bit. While the transfer is paused, both strobes are suppressed and the output enable is withdrawn, so the data output floats.

Entering and leaving the pause follows the serial clock phase. If the serial clock is low when the hold pin changes, the change takes effect at once. If the serial clock is high, the change waits until the next falling serial clock edge. The word assembler keeps its bit position and collected bits across a pause, so the transfer resumes where it stopped. Releasing chip select clears the pause at once, without waiting for the system clock, and throws away any partial word. When quad mode is enabled the hold pin carries data, and the pause function is switched off. Both idle-low (mode 0) and idle-high (mode 3) serial clock polarities work.

Top module: `spi_hold_gate`

## Requirements
- R1: During and right after reset, with chip select high, `outEn`, `holdState`, `driveStb` and `wordValid` are 0.
- R2: Each rising serial clock edge while selected and not paused captures `din`. Bits are assembled MSB first into a `WORD_W`-bit word, and `wordValid` pulses for one cycle with the completed word on `wordOut`.
- R3: Each falling serial clock edge while selected and not paused gives exactly one `driveStb` pulse. Falling edges during a pause give none.
- R4: A falling hold pin while the serial clock is low and chip select is low sets `holdState` without waiting for any serial clock edge.
- R5: A falling hold pin while the serial clock is high leaves `holdState` at 0 until the next falling serial clock edge. That edge still gives its `driveStb`, and `holdState` becomes 1 after it.
- R6: A rising hold pin while the serial clock is low clears `holdState` at once. While the serial clock is high, `holdState` stays 1 until the next falling serial clock edge, and that edge gives no `driveStb`.
- R7: While paused, serial clock edges and `din` changes are ignored. The bit position and the bits already collected are kept, so the word completes with the bits sent before and after the pause.
- R8: With `qe` = 1 the hold pin has no effect: `holdState` stays 0 and capture continues.
- R9: Chip select going high clears `holdState` without waiting for a system clock edge and discards any partial word. The next word starts again at its first bit.
- R10: `outEn` is 1 exactly when chip select is low and no pause is in effect.
- R11: The same behaviour holds when the serial clock idles high (mode 3): the first edge after select is a falling edge, and data is captured on the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| holdN | input | 1 | Hold pin, active low |
| din | input | 1 | Serial data-in pin |
| qe | input | 1 | Quad enable; 1 repurposes the hold pin as data |
| outEn | output | 1 | Data output drive enable; 0 means high impedance |
| driveStb | output | 1 | One-cycle strobe per accepted falling serial clock edge |
| holdState | output | 1 | 1 while the transfer is paused |
| wordOut | output | WORD_W | Last completed word, MSB received first |
| wordValid | output | 1 | One-cycle strobe when `wordOut` takes a new word |

## Verification
On every cycle the assertions check four things. A pause may only begin after the serial clock was seen low. A pause may only end with the serial clock seen low, unless chip select or quad mode ended it. While paused, the bit position is frozen and no drive strobe or output enable appears. A high chip select or quad enable keeps the pause cleared. Only the bench scenarios can show the outcomes over whole transfers: the deferral of entry and exit to the next falling edge, that the word assembled across pauses matches the bits sent, that a deselect mid-word discards the fragment, and that the drive strobe count matches the accepted falling edges. These outcomes are compared against a pin-level model driven by random hold episodes in both clock polarities.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // Pin values as seen after synchronization, with serial clock edge events
  typedef struct packed {
    logic csSeen;
    logic sckSeen;
    logic holdNSeen;
    logic dinSeen;
    logic qeSeen;
    logic sckRise;
    logic sckFall;
  } pinView_t;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic capture;
    logic drive;
    logic clearWord;
  } holdStrobe_t;

endpackage

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              holdN,
  input  logic              din,
  input  logic              qe,
  input  holdStrobe_t       stb,
  output pinView_t          view,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic [IDX_W-1:0]  bitIdx
);

  // Pin vector layout: bit0 csN, bit1 sck, bit2 holdN, bit3 din, bit4 qe
  localparam int PIN_N = 5;
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b00101;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic [PIN_N-1:0] pinRaw;
  logic [PIN_N-1:0] pinNow;
  logic [PIN_N-1:0] pinPrev;
  logic [WORD_W-1:0] shiftReg;

  assign pinRaw = {qe, din, holdN, sck, csN};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      logic [PIN_N-1:0] d;
      logic [PIN_N-1:0] q;
      if (g == 0) begin : g_first
        assign d = pinRaw;
      end else begin : g_next
        assign d = g_sync[g-1].q;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= PIN_IDLE;
        else       q <= d;
      end
    end
  endgenerate

  assign pinNow = g_sync[SYNC_STAGES-1].q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= PIN_IDLE;
    else       pinPrev <= pinNow;
  end

  always_comb begin
    view.csSeen    = pinNow[0];
    view.sckSeen   = pinNow[1];
    view.holdNSeen = pinNow[2];
    view.dinSeen   = pinNow[3];
    view.qeSeen    = pinNow[4];
    view.sckRise   = pinNow[1] & ~pinPrev[1];
    view.sckFall   = ~pinNow[1] & pinPrev[1];
  end

  // Word assembler: position and bits survive a pause untouched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitIdx    <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (stb.clearWord) begin
        shiftReg <= '0;
        bitIdx   <= '0;
      end else if (stb.capture) begin
        if (bitIdx == LAST_IDX) begin
          wordOut   <= {shiftReg[WORD_W-2:0], view.dinSeen};
          wordValid <= 1'b1;
          shiftReg  <= '0;
          bitIdx    <= '0;
        end else begin
          shiftReg <= {shiftReg[WORD_W-2:0], view.dinSeen};
          bitIdx   <= bitIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  pinView_t    view,
  output holdStrobe_t stb,
  output logic        holdActive,
  output logic        outEn
);

  logic selected;
  logic holdAllowed;
  logic holdReq;
  logic holdNext;

  assign selected    = ~view.csSeen;
  assign holdAllowed = selected & ~view.qeSeen;
  assign holdReq     = ~view.holdNSeen;

  // With the serial clock low the request is followed directly; with it
  // high the state is frozen, so a change lands on the next falling edge.
  assign holdNext = holdAllowed & (view.sckSeen ? holdActive : holdReq);

  // Deselect clears the pause without waiting for a system clock edge
  always_ff @(posedge clk or negedge rstN or posedge csN) begin
    if (!rstN)     holdActive <= 1'b0;
    else if (csN)  holdActive <= 1'b0;
    else           holdActive <= holdNext;
  end

  always_comb begin
    stb.capture   = selected & ~holdActive & view.sckRise;
    stb.drive     = selected & ~holdActive & view.sckFall;
    stb.clearWord = view.csSeen;
  end

  assign outEn = ~csN & selected & ~holdActive;

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              holdN,
  input  logic              din,
  input  logic              qe,
  output logic              outEn,
  output logic              driveStb,
  output logic              holdState,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  localparam int IDX_W = $clog2(WORD_W);

  pinView_t         pinView;
  holdStrobe_t      strobes;
  logic [IDX_W-1:0] dpBitIdx;

  spi_hold_dp #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sck       (sck),
    .holdN     (holdN),
    .din       (din),
    .qe        (qe),
    .stb       (strobes),
    .view      (pinView),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .bitIdx    (dpBitIdx)
  );

  spi_hold_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .view       (pinView),
    .stb        (strobes),
    .holdActive (holdState),
    .outEn      (outEn)
  );

  assign driveStb = strobes.drive;

endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             holdState,
  input logic             driveStb,
  input logic             outEn,
  input logic             csSeen,
  input logic             sckSeen,
  input logic             qeSeen,
  input logic [IDX_W-1:0] bitIdx
);

  // R4 R5
  hold_entry_sck_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdState) |-> !$past(sckSeen));

  // R6
  hold_exit_sck_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(holdState) && !csN && !$past(csSeen) && !$past(qeSeen)) |-> !$past(sckSeen));

  // R7
  hold_freezes_position_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdState && $past(holdState)) |-> $stable(bitIdx));

  // R3
  hold_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdState && $past(holdState)) |-> !driveStb);

  // R10
  hold_floats_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdState |-> !outEn);

  // R8
  quad_disables_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    qeSeen |=> !holdState);

  // R9
  deselect_clears_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !holdState);

endmodule

bind spi_hold_gate spi_hold_gate_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .holdState (holdState),
  .driveStb  (driveStb),
  .outEn     (outEn),
  .csSeen    (pinView.csSeen),
  .sckSeen   (pinView.sckSeen),
  .qeSeen    (pinView.qeSeen),
  .bitIdx    (dpBitIdx)
);

// File: tb/sim_spi_hold_gate.sv
`timescale 1ns/1ps
module sim_spi_hold_gate;

  localparam int WORD_W = 8;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, holdN = 1'b1, din = 1'b0, qe = 1'b0;
  logic outEn, driveStb, holdState, wordValid;
  logic [WORD_W-1:0] wordOut;

  always #2.5 clk = ~clk;

  spi_hold_gate #(.WORD_W(WORD_W)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN), .din(din), .qe(qe),
    .outEn(outEn), .driveStb(driveStb), .holdState(holdState),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  // Observed results
  int wordsSeen = 0;
  int drivesSeen = 0;
  logic [WORD_W-1:0] lastWord = '0;

  always @(posedge clk) begin
    if (rstN) begin
      if (wordValid) begin
        wordsSeen <= wordsSeen + 1;
        lastWord  <= wordOut;
      end
      if (driveStb) drivesSeen <= drivesSeen + 1;
    end
  end

  // Pin-level model
  bit csM = 1, sckM = 0, holdM = 1, dinM = 0, qeM = 0;
  bit expHold = 0;
  int expIdx = 0;
  int expWords = 0;
  int expDrives = 0;
  logic [WORD_W-1:0] expShift = '0;
  logic [WORD_W-1:0] expLast = '0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void modelSettle();
    if (csM || qeM) expHold = 0;
    else if (!sckM) expHold = !holdM;
  endfunction

  function automatic void modelSck(input bit v);
    bit old = sckM;
    sckM = v;
    if (!csM && !old && v && !expHold) begin
      expShift = {expShift[WORD_W-2:0], dinM};
      expIdx++;
      if (expIdx == WORD_W) begin
        expIdx = 0;
        expWords++;
        expLast = expShift;
        expShift = '0;
      end
    end
    if (!csM && old && !v && !expHold) expDrives++;
    modelSettle();
  endfunction

  task automatic checkAll(input string tag);
    chk(tag, "holdState", holdState, expHold);
    chk(tag, "outEn", outEn, (!csM && !expHold));
    chk(tag, "words", wordsSeen, expWords);
    chk(tag, "drives", drivesSeen, expDrives);
    if (expWords > 0) chk(tag, "lastWord", lastWord, expLast);
  endtask

  task automatic settle(input string tag);
    repeat (SETTLE) @(negedge clk);
    checkAll(tag);
  endtask

  task automatic setSck(input bit v, input string tag);
    @(negedge clk); sck = v; modelSck(v); settle(tag);
  endtask
  task automatic setHold(input bit v, input string tag);
    @(negedge clk); holdN = v; holdM = v; modelSettle(); settle(tag);
  endtask
  task automatic setDin(input bit v, input string tag);
    @(negedge clk); din = v; dinM = v; settle(tag);
  endtask
  task automatic setQe(input bit v, input string tag);
    @(negedge clk); qe = v; qeM = v; modelSettle(); settle(tag);
  endtask
  task automatic setCs(input bit v, input string tag);
    @(negedge clk); csN = v; csM = v;
    if (v) begin expIdx = 0; expShift = '0; end
    modelSettle();
    if (v) begin
      #1;
      chk("R9", "holdState cleared before clock edge", holdState, 0);
    end
    settle(tag);
  endtask

  // Random pause: hold low, some ignored clock pairs and data flips, hold high
  task automatic holdEpisode(input string tag);
    bit keepDin = dinM;
    int pairs = $urandom % 3;
    setHold(0, tag);
    for (int k = 0; k < pairs; k++) begin
      setSck(!sckM, tag);
      setDin($urandom % 2, tag);
      setSck(!sckM, tag);
    end
    if (dinM != keepDin) setDin(keepDin, tag);
    setHold(1, tag);
  endtask

  task automatic sendWord(input logic [WORD_W-1:0] data, input int holdPct, input string tag);
    bit idleHigh = sckM;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (idleHigh) setSck(0, tag);
      setDin(data[i], tag);
      if (($urandom % 100) < holdPct) holdEpisode(tag);
      setSck(1, tag);
      if (($urandom % 100) < holdPct) holdEpisode(tag);
      if (!idleHigh) setSck(0, tag);
    end
    chk(tag, "word equals data", lastWord, data);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "outEn in reset", outEn, 0);
    chk("R1", "holdState in reset", holdState, 0);
    chk("R1", "wordValid in reset", wordValid, 0);
    @(negedge clk); rstN = 1'b1;
    settle("R1");
    chk("R1", "driveStb after reset", driveStb, 0);

    // R2 R3 R10: plain mode 0 word
    setCs(0, "R10");
    sendWord(8'hA5, 0, "R2");
    sendWord(8'h3C, 0, "R3");

    // R4 R7 R6: pause with clock low, ignored edges, immediate release
    setDin(1, "R2");
    setSck(1, "R2");
    setSck(0, "R3");
    setHold(0, "R4");
    chk("R4", "held at once with clock low", holdState, 1);
    setSck(1, "R7");
    setDin(0, "R7");
    setSck(0, "R7");
    setDin(1, "R7");
    setHold(1, "R6");
    chk("R6", "released at once with clock low", holdState, 0);
    for (int i = 0; i < WORD_W - 1; i++) begin
      setDin(i % 2, "R7");
      setSck(1, "R7");
      setSck(0, "R7");
    end
    chk("R7", "word across pause", lastWord, 8'b1010_1010);

    // R5 R6: deferred entry and exit with clock high
    setDin(0, "R5");
    setSck(1, "R5");
    setHold(0, "R5");
    chk("R5", "entry deferred while clock high", holdState, 0);
    setSck(0, "R5");
    chk("R5", "held after falling edge", holdState, 1);
    setSck(1, "R6");
    setHold(1, "R6");
    chk("R6", "exit deferred while clock high", holdState, 1);
    setSck(0, "R6");
    chk("R6", "released after falling edge", holdState, 0);
    for (int i = 0; i < WORD_W - 1; i++) begin
      setDin(1, "R6");
      setSck(1, "R6");
      setSck(0, "R6");
    end
    chk("R6", "word after deferred pause", lastWord, 8'h7F);

    // R8: quad mode ignores hold
    setQe(1, "R8");
    setHold(0, "R8");
    chk("R8", "no pause with quad enabled", holdState, 0);
    sendWord(8'hC3, 0, "R8");
    setHold(1, "R8");
    setQe(0, "R8");

    // R9: deselect during pause discards fragment
    for (int i = 0; i < 3; i++) begin
      setDin(1, "R9");
      setSck(1, "R9");
      setSck(0, "R9");
    end
    setHold(0, "R9");
    setCs(1, "R9");
    setHold(1, "R9");
    setCs(0, "R9");
    sendWord(8'h81, 0, "R9");
    setCs(1, "R9");

    // R11: mode 3, clock idles high
    setSck(1, "R11");
    setCs(0, "R11");
    sendWord(8'h5A, 0, "R11");
    sendWord(8'hE1, 40, "R11");
    setCs(1, "R11");

    // Random words in both polarities with random pauses
    for (int n = 0; n < 12; n++) begin
      bit pol = $urandom % 2;
      logic [WORD_W-1:0] d = WORD_W'($urandom);
      setSck(pol, "R11");
      setCs(0, "R7");
      sendWord(d, 35, pol ? "R11" : "R7");
      setCs(1, "R9");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule